// File: doc/BRIEF.md
# GPIO Port Pin Control Unit

This block controls a bank of 16-pin general-purpose I/O ports through a small register bus. Each port has a direction register, an output-data register and a read-only input-data register. Every port except the last also has a pull-up register. One extra register switches the pins of a single chosen port into analog mode. From these settings the block produces, for every pin, an output enable, an output level and a pull-up enable. Pin levels come back through a two-flop synchronizer into the input-data registers.

A per-pin peripheral-select vector hands a pin to a peripheral. While a pin is handed over, the peripheral's own output-enable and output-level inputs drive it, and the GPIO direction and data bits have no effect on that pin. Analog mode sits above peripheral selection and GPIO settings. It turns off the output, removes the pull-up and makes the pin's input-data bit read 0.

The bus takes a write on every clock edge where `bus_we_i` is high. Read data is combinational from `bus_addr_i`. All offsets are byte addresses and must be word aligned. With default parameters there are ports 0 to 8: port 8 has no pull-up register, and port 1 is the analog-capable port.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the pull-up register of port 0 reads 0x0000001F, and every other pull-up, direction and output-data register reads 0. The analog-select register reads 0xFFFFFFFF, so all port-1 pins start in analog mode.
- R2: Registers sit at these offsets: pull-up of port n at 0x000+4n, direction at 0x200+4n, input-data at 0x300+4n, output-data at 0x400+4n, and analog-select at 0x500. Bit k (0..15) of each register maps to pin k of its port. Bits 31:16 read 0 for every register except analog-select, whose bits 31:16 read 0xFFFF. Unmapped or unaligned offsets read 0, and writes to them change nothing.
- R3: The input-data registers are read-only. A write to 0x300+4n changes no register and no pin output.
- R4: Input-data bit k of port n shows the level of pin_in_i[16n+k] as it was two clock edges earlier.
- R5: On a GPIO pin (not peripheral, not analog), direction bit 1 gives pin_oe_o=1 and pin_out_o equal to the output-data bit. Direction bit 0 gives pin_oe_o=0. pin_out_o is 0 whenever pin_oe_o is 0.
- R6: pin_pu_o is 1 only when the pull-up bit is 1 and the pin is not driving (pin_oe_o=0). This holds for both GPIO and peripheral inputs.
- R7: When periph_sel_i[i]=1 on a non-analog pin, pin_oe_o[i]=periph_oe_i[i] and pin_out_o[i]=periph_oe_i[i]&periph_out_i[i]. The direction and output-data bits are ignored for that pin but stay readable and writable.
- R8: An analog-select bit of 1 puts the matching port-1 pin into analog mode. In analog mode pin_oe_o=0, pin_out_o=0, pin_pu_o=0 and the input-data bit reads 0, even when the peripheral select is set. The mask takes effect in the cycle after the write.
- R9: Port 8 has no pull-up register. Offset 0x020 reads 0, and pin_pu_o of port 8 is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| pin_in_i | input | 144 | Pin levels, port n pin k at bit 16n+k |
| periph_sel_i | input | 144 | Per-pin peripheral ownership |
| periph_oe_i | input | 144 | Per-pin peripheral output enable |
| periph_out_i | input | 144 | Per-pin peripheral output level |
| pin_oe_o | output | 144 | Per-pin output enable |
| pin_out_o | output | 144 | Per-pin output level |
| pin_pu_o | output | 144 | Per-pin pull-up enable |

## Verification
An analog-select write and a change of the pin levels can land on the same clock edge. After that edge the input-data read applies the new mask right away, while the unmasked bits still show the pre-change levels for one more cycle. The bench drives both on one edge and checks the read one edge later and two edges later against hand-computed values. It also checks the port-1 pull-up outputs right after the write. Random rounds repeat this mix of analog, peripheral and GPIO settings, and a bench model predicts every output.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PIN_W = 16;
  localparam int unsigned ADDR_W = 12;
  localparam logic [3:0] PG_PU  = 4'h0;
  localparam logic [3:0] PG_DIR = 4'h2;
  localparam logic [3:0] PG_IN  = 4'h3;
  localparam logic [3:0] PG_OUT = 4'h4;
  localparam logic [3:0] PG_ANA = 4'h5;
  typedef logic [PIN_W-1:0] pin_vec_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign sync_o = sync_q;

  // R4
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (sync_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 9,
  parameter int unsigned PU_PORTS  = 8,
  parameter logic [PIN_W-1:0] PU0_RST = 16'h001F,
  parameter logic [PIN_W-1:0] ANA_RST = 16'hFFFF,
  localparam int unsigned W = NUM_PORTS * PIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [W-1:0]      in_data_i,
  output logic [W-1:0]      pu_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      dout_o,
  output pin_vec_t          ana_o,
  output logic [31:0]       rdata_o
);
  pin_vec_t pu_q   [PU_PORTS];
  pin_vec_t dir_q  [NUM_PORTS];
  pin_vec_t dout_q [NUM_PORTS];
  pin_vec_t ana_q;

  logic [3:0] page;
  logic [5:0] word;
  logic       aligned;

  assign page    = addr_i[11:8];
  assign word    = addr_i[7:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        dir_q[p]  <= '0;
        dout_q[p] <= '0;
      end
      for (int p = 0; p < PU_PORTS; p++) pu_q[p] <= (p == 0) ? PU0_RST : '0;
      ana_q <= ANA_RST;
    end else if (we_i && aligned) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (page == PG_DIR && word == 6'(p)) dir_q[p]  <= wdata_i[PIN_W-1:0];
        if (page == PG_OUT && word == 6'(p)) dout_q[p] <= wdata_i[PIN_W-1:0];
      end
      for (int p = 0; p < PU_PORTS; p++)
        if (page == PG_PU && word == 6'(p)) pu_q[p] <= wdata_i[PIN_W-1:0];
      if (page == PG_ANA && word == 6'd0) ana_q <= wdata_i[PIN_W-1:0];
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      dir_o[p*PIN_W +: PIN_W]  = dir_q[p];
      dout_o[p*PIN_W +: PIN_W] = dout_q[p];
      pu_o[p*PIN_W +: PIN_W]   = '0;
    end
    for (int p = 0; p < PU_PORTS; p++) pu_o[p*PIN_W +: PIN_W] = pu_q[p];
  end
  assign ana_o = ana_q;

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (page)
        PG_PU:
          for (int p = 0; p < PU_PORTS; p++)
            if (word == 6'(p)) rdata_o = {16'h0000, pu_q[p]};
        PG_DIR:
          for (int p = 0; p < NUM_PORTS; p++)
            if (word == 6'(p)) rdata_o = {16'h0000, dir_q[p]};
        PG_IN:
          for (int p = 0; p < NUM_PORTS; p++)
            if (word == 6'(p)) rdata_o = {16'h0000, in_data_i[p*PIN_W +: PIN_W]};
        PG_OUT:
          for (int p = 0; p < NUM_PORTS; p++)
            if (word == 6'(p)) rdata_o = {16'h0000, dout_q[p]};
        PG_ANA:
          if (word == 6'd0) rdata_o = {16'hFFFF, ana_q};
        default: rdata_o = '0;
      endcase
    end
  end

  // R2
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(aligned && page == PG_ANA && word == 6'd0) |-> (rdata_o[31:16] == 16'h0000));

  // R3
  in_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && aligned && page == PG_IN) |=> ($stable(dir_o) && $stable(dout_o) && $stable(pu_o) && $stable(ana_o)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 9,
  parameter int unsigned PU_PORTS  = 8,
  parameter int unsigned ANA_PORT  = 1,
  localparam int unsigned W = NUM_PORTS * PIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pu_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] dout_i,
  input  pin_vec_t     ana_i,
  input  logic [W-1:0] psel_i,
  input  logic [W-1:0] poe_i,
  input  logic [W-1:0] pout_i,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o,
  output logic [W-1:0] in_vis_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar b = 0; b < PIN_W; b++) begin : g_pin
      localparam int unsigned I = p * PIN_W + b;
      logic is_ana, oe, drv;

      if (p == ANA_PORT) begin : g_ana
        assign is_ana = ana_i[b];
      end else begin : g_dig
        assign is_ana = 1'b0;
      end

      always_comb begin
        if (is_ana) begin
          oe  = 1'b0;
          drv = 1'b0;
        end else if (psel_i[I]) begin
          oe  = poe_i[I];
          drv = pout_i[I];
        end else begin
          oe  = dir_i[I];
          drv = dout_i[I];
        end
      end

      assign oe_o[I]     = oe;
      assign out_o[I]    = oe & drv;
      assign pu_o[I]     = pu_i[I] & ~oe & ~is_ana;
      assign in_vis_o[I] = sync_i[I] & ~is_ana;

      // R6
      pu_in_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(oe_o[I] && pu_o[I]));
      // R5
      gpio_in_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!is_ana && !psel_i[I] && !dir_i[I]) |-> (!oe_o[I] && !out_o[I]));
      // R7
      periph_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!is_ana && psel_i[I]) |-> (oe_o[I] == poe_i[I]));
      // R8
      ana_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_ana |-> (!oe_o[I] && !out_o[I] && !pu_o[I] && !in_vis_o[I]));
      if (p >= PU_PORTS) begin : g_nopu
        // R9
        no_pu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !pu_o[I]);
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 9,
  parameter int unsigned PU_PORTS  = 8,
  parameter int unsigned ANA_PORT  = 1,
  localparam int unsigned W = NUM_PORTS * PIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [W-1:0]      pin_in_i,
  input  logic [W-1:0]      periph_sel_i,
  input  logic [W-1:0]      periph_oe_i,
  input  logic [W-1:0]      periph_out_i,
  output logic [W-1:0]      pin_oe_o,
  output logic [W-1:0]      pin_out_o,
  output logic [W-1:0]      pin_pu_o
);
  logic [W-1:0] pu_bits, dir_bits, dout_bits, sync_bits, in_vis;
  pin_vec_t     ana_bits;

  gpio_in_sync #(.W(W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_in_i),
    .sync_o (sync_bits)
  );

  gpio_regs #(.NUM_PORTS(NUM_PORTS), .PU_PORTS(PU_PORTS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .in_data_i (in_vis),
    .pu_o      (pu_bits),
    .dir_o     (dir_bits),
    .dout_o    (dout_bits),
    .ana_o     (ana_bits),
    .rdata_o   (bus_rdata_o)
  );

  gpio_pin_mux #(.NUM_PORTS(NUM_PORTS), .PU_PORTS(PU_PORTS), .ANA_PORT(ANA_PORT)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pu_i     (pu_bits),
    .dir_i    (dir_bits),
    .dout_i   (dout_bits),
    .ana_i    (ana_bits),
    .psel_i   (periph_sel_i),
    .poe_i    (periph_oe_i),
    .pout_i   (periph_out_i),
    .sync_i   (sync_bits),
    .oe_o     (pin_oe_o),
    .out_o    (pin_out_o),
    .pu_o     (pin_pu_o),
    .in_vis_o (in_vis)
  );
endmodule

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
  localparam int NP = 9;
  localparam int PW = 16;
  localparam int W  = NP * PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [W-1:0] pin_in = '0, psel = '0, poe = '0, pout = '0;
  logic [W-1:0] po_oe, po_out, po_pu;

  logic [15:0] m_pu [NP];
  logic [15:0] m_dir [NP];
  logic [15:0] m_dout [NP];
  logic [15:0] m_ana;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  gpio_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_in_i(pin_in),
    .periph_sel_i(psel), .periph_oe_i(poe), .periph_out_i(pout),
    .pin_oe_o(po_oe), .pin_out_o(po_out), .pin_pu_o(po_pu)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_pu[p] = (p == 0) ? 16'h001F : 16'h0000;
      m_dir[p] = '0;
      m_dout[p] = '0;
    end
    m_ana = 16'hFFFF;
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int w;
    w = int'(a[7:2]);
    if (a[1:0] == 2'b00) begin
      case (a[11:8])
        4'h0: if (w < NP - 1) m_pu[w] = d[15:0];
        4'h2: if (w < NP) m_dir[w] = d[15:0];
        4'h4: if (w < NP) m_dout[w] = d[15:0];
        4'h5: if (w == 0) m_ana = d[15:0];
        default: ;
      endcase
    end
  endtask

  // expected input-data read assumes pins stable for at least two edges
  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int w;
    w = int'(a[7:2]);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[11:8])
      4'h0: return (w < NP - 1) ? {16'h0, m_pu[w]} : 32'h0;
      4'h2: return (w < NP) ? {16'h0, m_dir[w]} : 32'h0;
      4'h3: return (w < NP) ? {16'h0, pin_in[w*PW +: PW] & ((w == 1) ? ~m_ana : 16'hFFFF)} : 32'h0;
      4'h4: return (w < NP) ? {16'h0, m_dout[w]} : 32'h0;
      4'h5: return (w == 0) ? {16'hFFFF, m_ana} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic exp_pins(output logic [W-1:0] e_oe, output logic [W-1:0] e_out, output logic [W-1:0] e_pu);
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < PW; b++) begin
        int i;
        logic ana, pub, oe;
        i = p * PW + b;
        ana = (p == 1) && m_ana[b];
        pub = (p < NP - 1) ? m_pu[p][b] : 1'b0;
        if (ana) oe = 1'b0;
        else if (psel[i]) oe = poe[i];
        else oe = m_dir[p][b];
        e_oe[i]  = oe;
        e_out[i] = ana ? 1'b0 : (psel[i] ? (oe & pout[i]) : (oe & m_dout[p][b]));
        e_pu[i]  = pub & ~oe & ~ana;
      end
  endtask

  task automatic chk_pins(input string tag);
    logic [W-1:0] e_oe, e_out, e_pu;
    exp_pins(e_oe, e_out, e_pu);
    chk({tag, " oe"}, po_oe, e_oe);
    chk({tag, " out"}, po_out, e_out);
    chk({tag, " pu"}, po_pu, e_pu);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
  endtask

  task automatic read_chk(input logic [11:0] a, input string tag);
    addr = a;
    #2;
    chk(tag, W'(rdata), W'(exp_read(a)));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int p = 0; p < NP; p++) begin
      read_chk(12'(p * 4), "R1 pull-up reset");
      read_chk(12'h200 + 12'(p * 4), "R1 direction reset");
      read_chk(12'h400 + 12'(p * 4), "R1 output-data reset");
    end
    read_chk(12'h500, "R1 analog reset");
    chk("R1 pull-up pins at reset", po_pu, W'(16'h001F));
    chk("R1 oe at reset", po_oe, '0);

    // R2 upper bits and unmapped
    bus_write(12'h204, 32'hABCD_1234);
    read_chk(12'h204, "R2 upper bits zero");
    read_chk(12'h600, "R2 unmapped page");
    read_chk(12'h224, "R2 beyond last port");
    read_chk(12'h206, "R2 unaligned");
    bus_write(12'h202, 32'h0000_FFFF);
    read_chk(12'h200, "R2 unaligned write ignored");

    // R9 no pull-up on port 8
    bus_write(12'h020, 32'h0000_FFFF);
    read_chk(12'h020, "R9 offset reads zero");
    bus_write(12'h000 + 12'(8 * 4), 32'h0000_FFFF);
    chk("R9 port 8 pull-up", W'(po_pu[8*PW +: PW]), '0);

    // R4 latency, clear analog first
    bus_write(12'h500, 32'h0);
    @(negedge clk);
    pin_in[PW-1:0] = 16'hA5A5;
    @(negedge clk);
    addr = 12'h300; #2;
    chk("R4 after one edge", W'(rdata), W'(32'h0));
    @(negedge clk);
    addr = 12'h300; #2;
    chk("R4 after two edges", W'(rdata), W'(32'h0000_A5A5));

    // R3 input-data write ignored
    bus_write(12'h300, 32'hFFFF_FFFF);
    read_chk(12'h300, "R3 input-data unchanged");
    read_chk(12'h200, "R3 direction unchanged");
    chk_pins("R3 pins unchanged");

    // R7 peripheral override on port 2
    bus_write(12'h208, 32'h0000_FFFF);
    bus_write(12'h408, 32'h0000_AAAA);
    bus_write(12'h008, 32'h0000_FFFF);
    @(negedge clk);
    psel[2*PW +: PW] = 16'h00FF;
    poe[2*PW +: PW]  = 16'h0F0F;
    pout[2*PW +: PW] = 16'hFFFF;
    #2;
    chk("R7 oe mix", W'(po_oe[2*PW +: PW]), W'(16'hFF0F));
    chk("R7 out mix", W'(po_out[2*PW +: PW]), W'(16'hAA0F));
    chk("R6 peripheral input pull-up", W'(po_pu[2*PW +: PW]), W'(16'h00F0));
    read_chk(12'h408, "R7 output-data still readable");

    // R8 analog beats peripheral, same edge as pin change
    bus_write(12'h004, 32'h0000_FFFF);
    @(negedge clk);
    pin_in[PW +: PW] = 16'hFFFF;
    psel[PW +: PW] = 16'hFFFF;
    poe[PW +: PW]  = 16'h0000;
    repeat (3) @(negedge clk);
    addr = 12'h304; #2;
    chk("R8 baseline read", W'(rdata), W'(32'h0000_FFFF));
    @(negedge clk);
    pin_in[PW +: PW] = 16'h0F0F;
    poe[PW +: PW] = 16'h00F0;
    we = 1'b1; addr = 12'h500; wdata = 32'h0000_00FF;
    @(negedge clk);
    we = 1'b0; model_write(12'h500, 32'h0000_00FF);
    addr = 12'h304; #2;
    chk("R8 mask with old pins", W'(rdata), W'(32'h0000_FF00));
    chk("R8 analog pull-up off", W'(po_pu[PW +: PW]), W'(16'hFF00));
    chk("R8 analog oe off", W'(po_oe[PW +: PW]), W'(16'h0000));
    @(negedge clk);
    addr = 12'h304; #2;
    chk("R8 mask with new pins", W'(rdata), W'(32'h0000_0F00));

    // random rounds: R2 R5 R6 R7 R8
    for (int n = 0; n < 250; n++) begin
      logic [11:0] a;
      int k, prt;
      k = int'($urandom % 5);
      prt = int'($urandom % NP);
      case (k)
        0: a = 12'h000 + 12'(prt * 4);
        1: a = 12'h200 + 12'(prt * 4);
        2: a = 12'h400 + 12'(prt * 4);
        3: a = 12'h500;
        default: a = 12'h300 + 12'(prt * 4);
      endcase
      bus_write(a, $urandom);
      for (int j = 0; j < NP; j++) begin
        pin_in[j*PW +: PW] = 16'($urandom);
        psel[j*PW +: PW]   = 16'($urandom & $urandom);
        poe[j*PW +: PW]    = 16'($urandom);
        pout[j*PW +: PW]   = 16'($urandom);
      end
      repeat (3) @(negedge clk);
      chk_pins("R5/R6/R7/R8 random");
      read_chk(12'h300 + 12'(prt * 4), "R4/R8 random input-data");
      read_chk(a, "R2 random readback");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule